// File: doc/BRIEF.md
# Asynchronous single-bit SRAM access controller

This block sits between a clocked host and an external asynchronous static RAM of 16,384 one-bit words. The host raises a request with a direction bit, a 14-bit address and, for writes, one data bit. The controller then runs the RAM pins through a fixed access sequence timed in system clocks. It drives the address bus, an active-low chip select, an active-low write strobe and a data-in pin, and it samples the RAM's separate data-out pin. Each access ends with a one-cycle acknowledge.

Host inputs are latched at the clock edge that accepts the request. Changes on those inputs during the access have no effect. The chip select is held low for the whole access and high between accesses, so the RAM falls back to standby whenever the host is quiet. A write is the overlap of chip select and write strobe. The strobe always rises first and ends the write, and the chip select stays low for a short hold period after it. A read keeps the strobe high, waits the configured number of clocks, and captures the data-out pin into the `rdata` register before the chip select is released.

The state machine has five states. ST_IDLE waits for `req` and moves to ST_RD_WAIT (when `we`=0) or ST_WR_PULSE (when `we`=1). ST_RD_WAIT moves to ST_DONE after READ_CYC clocks. ST_WR_PULSE moves to ST_WR_HOLD after WR_PULSE_CYC clocks. ST_WR_HOLD moves to ST_DONE after HOLD_CYC clocks. ST_DONE returns to ST_IDLE after one clock. The acknowledge is high only while the machine is in ST_DONE. READ_CYC and WR_PULSE_CYC are the RAM's read time and write-pulse time divided by the clock period, rounded up.

Top module: `sram_async_ctl`

## Requirements
- R1: A synchronous active-high reset, including one applied in the middle of an access, leaves `sram_ce_n`=1, `sram_we_n`=1, `ack`=0 and `rdata`=0 from the first edge at which it is seen.
- R2: Whenever no access is in progress (before acceptance and after the acknowledge cycle), `sram_ce_n` and `sram_we_n` are both 1.
- R3: A read (`we`=0) holds `sram_ce_n`=0 and `sram_we_n`=1 for exactly READ_CYC clocks. The data-out pin is sampled only in that window, on its last edge, into `rdata`. `ack` is high in the cycle after that edge, so it appears READ_CYC+1 edges after the accepting edge.
- R4: A write (`we`=1) holds `sram_we_n`=0 for exactly WR_PULSE_CYC clocks, with `sram_din` equal to the requested bit and `sram_addr` stable throughout. `sram_we_n` rises while `sram_ce_n` is still 0, and `sram_ce_n` stays 0 for HOLD_CYC further clocks.
- R5: A write's `ack` appears WR_PULSE_CYC+HOLD_CYC+1 edges after the accepting edge.
- R6: `ack` is high for exactly one cycle per access, and `sram_ce_n` and `sram_we_n` are both 1 in that cycle.
- R7: `addr`, `we` and `wdata` are taken at the accepting edge. Changing them while the access runs alters neither the RAM pins nor the location or value written.
- R8: `rdata` keeps the last read value across later writes, until the next read completes.
- R9: `sram_we_n` is never 0 while `sram_ce_n` is 1.
- R10: All 16,384 locations are reachable, including address 0 and address 16383.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Host request, held until `ack` |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 14 | Host word address |
| wdata | input | 1 | Bit to write |
| rdata | output | 1 | Last bit read |
| ack | output | 1 | One-cycle completion strobe |
| sram_addr | output | 14 | RAM address bus |
| sram_ce_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_din | output | 1 | RAM data-in pin |
| sram_dout | input | 1 | RAM data-out pin |

## Verification
The bench builds the controller with READ_CYC=5, WR_PULSE_CYC=4 and HOLD_CYC=1. At a 4 ns clock these give a 20 ns read window and a 16 ns write pulse. With these values an early sample or a short strobe is visible in every access. The bench's RAM model returns the inverted bit until the chip select has been low for five clocks, and it only commits a write whose pulse lasts exactly four clocks. Because the counts are small, several hundred random accesses across the full address range fit in a short run, together with directed cases at both address ends, inputs changed mid-access, and a reset that lands inside a write pulse.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_WAIT  = 3'd1,
        ST_WR_PULSE = 3'd2,
        ST_WR_HOLD  = 3'd3,
        ST_DONE     = 3'd4
    } ctl_state_e;

endpackage

// File: rtl/sram_wait_ctr.sv
module sram_wait_ctr #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             en,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = en && (cnt == limit - 1'b1);

    // the wait counter never runs past the window it is timing
    AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        en |-> (cnt < limit))
        else $error("wait counter beyond limit"); // R3

endmodule

// File: rtl/sram_req_latch.sv
module sram_req_latch #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wdata_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wdata_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_o  <= '0;
            wdata_o <= 1'b0;
        end else if (load) begin
            addr_o  <= addr_i;
            wdata_o <= wdata_i;
        end
    end

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture (
    input  logic clk,
    input  logic rst,
    input  logic cap,
    input  logic d,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (cap) begin
            q <= d;
        end
    end

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W       = 14,
    parameter int READ_CYC     = 5,
    parameter int WR_PULSE_CYC = 4,
    parameter int HOLD_CYC     = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wdata,
    output logic              rdata,
    output logic              ack,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_din,
    input  logic              sram_dout
);

    localparam int MAX_RW  = (READ_CYC > WR_PULSE_CYC) ? READ_CYC : WR_PULSE_CYC;
    localparam int MAX_CYC = (MAX_RW > HOLD_CYC) ? MAX_RW : HOLD_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] LIM_RD   = CNT_W'(READ_CYC);
    localparam logic [CNT_W-1:0] LIM_WR   = CNT_W'(WR_PULSE_CYC);
    localparam logic [CNT_W-1:0] LIM_HOLD = CNT_W'(HOLD_CYC);

    ctl_state_e       state;
    ctl_state_e       nxt;
    logic             accept;
    logic             wait_en;
    logic             wait_last;
    logic             ctr_clear;
    logic             rd_cap;
    logic [CNT_W-1:0] wait_limit;

    logic             ce_n_q;
    logic             we_n_q;
    logic             ack_q;

    assign accept    = (state == ST_IDLE) && req;
    assign wait_en   = (state == ST_RD_WAIT) || (state == ST_WR_PULSE) || (state == ST_WR_HOLD);
    assign ctr_clear = (state != nxt);
    assign rd_cap    = (state == ST_RD_WAIT) && wait_last;

    always_comb begin
        wait_limit = {{(CNT_W-1){1'b0}}, 1'b1};
        unique case (state)
            ST_RD_WAIT:  wait_limit = LIM_RD;
            ST_WR_PULSE: wait_limit = LIM_WR;
            ST_WR_HOLD:  wait_limit = LIM_HOLD;
            default:     wait_limit = {{(CNT_W-1){1'b0}}, 1'b1};
        endcase
    end

    // next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (req) begin
                    nxt = we ? ST_WR_PULSE : ST_RD_WAIT;
                end
            end
            ST_RD_WAIT: begin
                if (wait_last) nxt = ST_DONE;
            end
            ST_WR_PULSE: begin
                if (wait_last) nxt = ST_WR_HOLD;
            end
            ST_WR_HOLD: begin
                if (wait_last) nxt = ST_DONE;
            end
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // registered pin and strobe outputs, decoded from the next state
    always_ff @(posedge clk) begin
        if (rst) begin
            ce_n_q <= 1'b1;
            we_n_q <= 1'b1;
            ack_q  <= 1'b0;
        end else begin
            ce_n_q <= !((nxt == ST_RD_WAIT) || (nxt == ST_WR_PULSE) || (nxt == ST_WR_HOLD));
            we_n_q <= (nxt != ST_WR_PULSE);
            ack_q  <= (nxt == ST_DONE);
        end
    end

    assign sram_ce_n = ce_n_q;
    assign sram_we_n = we_n_q;
    assign ack       = ack_q;

    sram_wait_ctr #(
        .CNT_W (CNT_W)
    ) u_wait (
        .clk   (clk),
        .rst   (rst),
        .clear (ctr_clear),
        .en    (wait_en),
        .limit (wait_limit),
        .last  (wait_last)
    );

    sram_req_latch #(
        .ADDR_W (ADDR_W)
    ) u_latch (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .addr_i  (addr),
        .wdata_i (wdata),
        .addr_o  (sram_addr),
        .wdata_o (sram_din)
    );

    sram_rd_capture u_cap (
        .clk (clk),
        .rst (rst),
        .cap (rd_cap),
        .d   (sram_dout),
        .q   (rdata)
    );

    AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> !sram_ce_n)
        else $error("write strobe outside chip select"); // R9

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack)
        else $error("ack longer than one cycle"); // R6

    AST_ACK_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        ack |-> (sram_ce_n && sram_we_n))
        else $error("pins active during ack"); // R6

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr))
        else $error("address moved during access"); // R7

    AST_DIN_HELD: assert property (@(posedge clk) disable iff (rst)
        (!sram_we_n && $past(!sram_we_n)) |-> $stable(sram_din))
        else $error("data-in moved during pulse"); // R4

    AST_WE_ENDS_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_ce_n) |-> $past(sram_we_n))
        else $error("chip select ended the write"); // R4

    AST_SAMPLE_IN_READ: assert property (@(posedge clk) disable iff (rst)
        rd_cap |-> (sram_we_n && !sram_ce_n))
        else $error("read sampled outside read window"); // R3

endmodule

// File: tb/sram_async_ctl_tb.sv
module sram_async_ctl_tb;

    localparam int AW    = 14;
    localparam int DEPTH = 1 << AW;
    localparam int RD_C  = 5;
    localparam int WP_C  = 4;
    localparam int HD_C  = 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          wdata = 1'b0;
    logic          rdata;
    logic          ack;
    logic [AW-1:0] sram_addr;
    logic          sram_ce_n;
    logic          sram_we_n;
    logic          sram_din;
    logic          sram_dout;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    bit model_mem [0:DEPTH-1];
    bit ref_mem   [0:DEPTH-1];

    always #2 clk = ~clk;

    sram_async_ctl #(
        .ADDR_W(AW), .READ_CYC(RD_C), .WR_PULSE_CYC(WP_C), .HOLD_CYC(HD_C)
    ) u_dut (
        .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ack(ack), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
        .sram_we_n(sram_we_n), .sram_din(sram_din), .sram_dout(sram_dout)
    );

    function automatic bit init_pat(int i);
        return bit'((i ^ (i >> 5)) & 1);
    endfunction

    task automatic check(bit ok, string rq, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    // RAM model: output is wrong until select has been low long enough
    int ce_cnt = 0;
    always @(posedge clk) ce_cnt <= sram_ce_n ? 0 : ce_cnt + 1;
    assign sram_dout = (!sram_ce_n && sram_we_n && ce_cnt >= RD_C - 1)
                       ? model_mem[sram_addr] : ~model_mem[sram_addr];

    // write and idle monitor at the falling edge
    int      w_cnt = 0;
    int      h_cnt = 0;
    bit      h_on = 1'b0;
    logic [AW-1:0] w_a;
    bit      w_d;
    always @(negedge clk) begin
        if (rst) begin
            w_cnt = 0; h_on = 1'b0; h_cnt = 0;
        end else begin
            if (sram_ce_n && !sram_we_n)
                check(1'b0, "R9 strobe without select", 0, 1);
            if (!sram_ce_n && !sram_we_n) begin
                if (w_cnt > 0) begin
                    check(sram_din == w_d, "R4 din stable", int'(sram_din), int'(w_d));
                    check(sram_addr == w_a, "R4 addr stable", int'(sram_addr), int'(w_a));
                end
                w_cnt++;
                w_a = sram_addr;
                w_d = sram_din;
            end else if (w_cnt > 0) begin
                check(w_cnt == WP_C, "R4 pulse length", w_cnt, WP_C);
                check(!sram_ce_n, "R4 strobe rises first", int'(sram_ce_n), 0);
                if (w_cnt == WP_C) model_mem[w_a] = w_d;
                w_cnt = 0;
                h_on = 1'b1;
                h_cnt = 1;
            end else if (h_on) begin
                if (sram_ce_n) begin
                    check(h_cnt == HD_C, "R4 hold length", h_cnt, HD_C);
                    h_on = 1'b0;
                end else begin
                    h_cnt++;
                end
            end
        end
    end

    task automatic access(input bit w, input logic [AW-1:0] a, input bit d,
                          input bit scramble, output int lat);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            if (scramble && lat == 2) begin
                addr = ~a; wdata = ~d; we = ~w;
            end
        end while (!ack && lat < 100);
        req = 1'b0;
        check(sram_ce_n && sram_we_n, "R6 deselected during ack",
              int'({sram_ce_n, sram_we_n}), 3);
        if (w) ref_mem[a] = d;
        @(negedge clk);
        check(!ack, "R6 ack single cycle", int'(ack), 0);
        check(sram_ce_n && sram_we_n, "R2 idle deselect",
              int'({sram_ce_n, sram_we_n}), 3);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input bit d, input bit scr);
        int lat;
        access(1'b1, a, d, scr, lat);
        check(lat == WP_C + HD_C + 1, "R5 write latency", lat, WP_C + HD_C + 1);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input string rq);
        int lat;
        access(1'b0, a, 1'b0, 1'b0, lat);
        check(lat == RD_C + 1, "R3 read latency", lat, RD_C + 1);
        check(rdata == ref_mem[a], rq, int'(rdata), int'(ref_mem[a]));
    endtask

    initial begin
        int cyc = 0;
        while (!done_flag) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        bit prev;
        for (int i = 0; i < DEPTH; i++) begin
            model_mem[i] = init_pat(i);
            ref_mem[i]   = init_pat(i);
        end
        void'($urandom(32'h5EED_0167));
        repeat (3) @(negedge clk);
        check(sram_ce_n && sram_we_n && !ack && !rdata, "R1 reset state",
              int'({sram_ce_n, sram_we_n, ack, rdata}), 12);
        rst = 1'b0;
        @(negedge clk);
        check(sram_ce_n && sram_we_n, "R2 idle after reset",
              int'({sram_ce_n, sram_we_n}), 3);

        // R10 address ends
        do_write(14'd0, ~init_pat(0), 1'b0);
        do_write(14'h3FFF, ~init_pat(16383), 1'b0);
        do_read(14'd0, "R10 low end");
        do_read(14'h3FFF, "R10 high end");

        // R8 rdata held across a write
        do_read(14'd77, "R3 read value");
        prev = rdata;
        do_write(14'd78, ~ref_mem[78], 1'b0);
        check(rdata == prev, "R8 rdata held", int'(rdata), int'(prev));

        // R7 inputs changed mid-access are ignored
        do_write(14'h1234, ~ref_mem[14'h1234], 1'b1);
        do_read(14'h1234, "R7 latched write value");
        do_read(~14'h1234, "R7 other address untouched");

        // R1 reset inside a write pulse
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 14'd100; wdata = ~ref_mem[100];
        repeat (2) @(negedge clk);
        rst = 1'b1; req = 1'b0;
        @(negedge clk);
        check(sram_ce_n && sram_we_n && !ack && !rdata, "R1 reset mid-access",
              int'({sram_ce_n, sram_we_n, ack, rdata}), 12);
        @(negedge clk);
        rst = 1'b0;
        do_write(14'd100, 1'b1, 1'b0);
        do_read(14'd100, "R1 recovery after reset");

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [AW-1:0] a;
            if ($urandom_range(1, 0) == 1) a = AW'($urandom_range(7, 0) * 2047);
            else a = AW'($urandom);
            if ($urandom_range(1, 0) == 1)
                do_write(a, bit'($urandom_range(1, 0)), bit'($urandom_range(3, 0) == 0));
            else
                do_read(a, "R3 random read");
        end

        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule